// File: doc/BRIEF.md
# Scalar Floating-Point Precision Converter

This unit executes a single scalar instruction that changes the precision of a floating-point value among the half (16-bit), single (32-bit) and double (64-bit) binary formats. It decodes the 32-bit instruction word, unpacks the source operand into a common wide form, and rounds and packs it into the requested destination format. It also builds the full 128-bit register write value, placing the result in the lowest element and either keeping or clearing the rest.

Results are registered. The outputs for an instruction presented with `in_valid` appear on the clock edge that samples it. The rounding mode and the merge control are sampled in the same cycle as the instruction. An instruction word that is not a legal member of this conversion family produces no write and raises an illegal-encoding indication. No arithmetic flags are raised in that case.

Top module: `fp_precision_cvt`

## Requirements
- R1: A word is in the family only when bits 31:24 equal 0x1E, bits 21:17 equal 10001 and bits 14:10 equal 10000. For a legal word, `wr_en` is 1 and `dst_idx` equals bits 4:0.
- R2: Bits 23:22 give the source format and bits 16:15 give the destination format. In both fields the code 00 means single, 01 means double and 11 means half.
- R3: A word fails decoding when the fixed bits of R1 differ, when either format field holds 10, or when both fields are equal. The unit then reports `illegal`=1, `wr_en`=0, `wr_data`=0 and `fflags`=0.
- R4: The converted value occupies the lowest 16, 32 or 64 bits of `wr_data`, matching the destination width. When `merge`=1, the bits above come from `dst_old`. When `merge`=0, they are zero.
- R5: Widening is exact and raises no flag. Subnormal sources become normal values of the wider format. Zeros and infinities keep their sign in every direction.
- R6: Narrowing rounds according to `rmode`: 00 to nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero. `fflags` bit 0 (inexact) is set whenever the result differs from the operand.
- R7: When a narrowed magnitude exceeds the destination range, before or after rounding, the result is an infinity or the largest finite value with the operand's sign. Infinity is chosen for nearest, for upward rounding of a positive value and for downward rounding of a negative value. `fflags` bit 2 (overflow) and bit 0 are set.
- R8: A nonzero value whose unbounded exponent lies below the destination's smallest normal exponent is tiny; tininess is judged before rounding. A tiny value is rounded into a subnormal or zero. `fflags` bit 1 (underflow) is set when the value is tiny and inexact.
- R9: Every NaN operand yields a quiet NaN of the destination format with the same sign. Below the forced quiet bit, the NaN keeps the leading fraction bits that fit. A signaling NaN sets `fflags` bit 3 (invalid).
- R10: `out_valid`, `wr_en` and `illegal` reflect the instruction sampled at the previous clock edge. All outputs are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source register contents (low 64 bits) |
| dst_old | input | 128 | Previous destination register contents |
| rmode | input | 2 | Rounding mode |
| merge | input | 1 | Keep upper destination bits when 1 |
| out_valid | output | 1 | A result was produced |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 128 | Register write value |
| illegal | output | 1 | Instruction word not in the family |
| fflags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The bench aims at the points where narrowing goes wrong. It uses halfway cases under every rounding mode: a design that rounds ties away from zero returns an odd half-precision value. It uses rounding that carries into an all-ones exponent: a design that checks overflow only before rounding emits a bogus finite pattern. It uses values a half or a whole step below the smallest subnormal, and doubles so small that every bit becomes sticky: a sticky collector that misses shifted-out bits returns zero with no underflow. It also uses single subnormals widened to double, signaling and quiet NaNs with payloads, and encodings with the reserved format code or equal fields. A wrong decoder would write results for those.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

  localparam int EXP_W  = 13;
  localparam int MANT_W = 53;

  typedef enum logic [1:0] {
    FMT_S   = 2'b00,
    FMT_D   = 2'b01,
    FMT_BAD = 2'b10,
    FMT_H   = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                     sign;
    logic                     zero;
    logic                     inf;
    logic                     nan;
    logic                     snan;
    logic signed [EXP_W-1:0]  exp;
    logic [MANT_W-1:0]        mant;
  } unp_t;

  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic nx;
  } flags_t;

  function automatic int fmt_ew(input int k);
    return (k == 0) ? 5 : (k == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_mw(input int k);
    return (k == 0) ? 10 : (k == 1) ? 23 : 52;
  endfunction

endpackage

// File: rtl/pcv_decode.sv
module pcv_decode
  import pcv_pkg::*;
(
  input  logic [31:0] instr,
  output logic        legal,
  output fmt_e        src_fmt,
  output fmt_e        dst_fmt,
  output logic [4:0]  rd
);

  logic fixed_ok;
  logic unused_rn;

  assign unused_rn = ^instr[9:5];

  always_comb begin
    fixed_ok = (instr[31:24] == 8'h1E) &&
               (instr[21:17] == 5'b10001) &&
               (instr[14:10] == 5'b10000);
    src_fmt  = fmt_e'(instr[23:22]);
    dst_fmt  = fmt_e'(instr[16:15]);
    rd       = instr[4:0];
    legal    = fixed_ok && (src_fmt != FMT_BAD) && (dst_fmt != FMT_BAD) &&
               (src_fmt != dst_fmt);
  end

endmodule

// File: rtl/pcv_unpack.sv
module pcv_unpack
  import pcv_pkg::*;
(
  input  fmt_e        fmt,
  input  logic [63:0] raw,
  output unp_t        u
);

  logic [10:0]             ef;
  logic [10:0]             ef_max;
  logic [51:0]             fr;
  logic                    sgn;
  logic signed [EXP_W-1:0] bias;
  logic [5:0]              lz;

  function automatic logic [5:0] lzc52(input logic [51:0] v);
    logic [5:0] n;
    n = 6'd0;
    for (int i = 0; i < 52; i++) begin
      if (v[i]) n = 6'(51 - i);
    end
    return n;
  endfunction

  always_comb begin
    case (fmt)
      FMT_H: begin
        ef     = {6'b0, raw[14:10]};
        ef_max = 11'd31;
        fr     = {raw[9:0], 42'b0};
        sgn    = raw[15];
        bias   = 13'sd15;
      end
      FMT_S: begin
        ef     = {3'b0, raw[30:23]};
        ef_max = 11'd255;
        fr     = {raw[22:0], 29'b0};
        sgn    = raw[31];
        bias   = 13'sd127;
      end
      default: begin
        ef     = raw[62:52];
        ef_max = 11'd2047;
        fr     = raw[51:0];
        sgn    = raw[63];
        bias   = 13'sd1023;
      end
    endcase

    lz     = lzc52(fr);
    u.sign = sgn;
    u.inf  = (ef == ef_max) && (fr == '0);
    u.nan  = (ef == ef_max) && (fr != '0);
    u.snan = u.nan && !fr[51];
    u.zero = (ef == '0) && (fr == '0);
    if (ef == '0) begin
      u.exp  = -bias - $signed({7'b0, lz});
      u.mant = {fr, 1'b0} << lz;
    end else begin
      u.exp  = $signed({2'b0, ef}) - bias;
      u.mant = {1'b1, fr};
    end
  end

endmodule

// File: rtl/pcv_round_pack.sv
module pcv_round_pack
  import pcv_pkg::*;
#(
  parameter int EW = 5,
  parameter int MW = 10
) (
  input  unp_t        u,
  input  logic [1:0]  rmode,
  output logic [63:0] res,
  output flags_t      fl
);

  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SW   = MANT_W + 2;
  localparam int TW   = 1 + EW + MW;
  localparam logic signed [EXP_W-1:0] EMIN_S = EXP_W'(1 - BIAS);
  localparam logic signed [EXP_W-1:0] EMAX_S = EXP_W'(BIAS);

  logic                    tiny;
  logic signed [EXP_W-1:0] diff;
  logic [5:0]              sh;
  logic [SW-1:0]           sig;
  logic [SW-1:0]           shd;
  logic [SW-1:0]           lmask;
  logic                    lost, g, st, inc, pre_ovf, post_ovf, ovf, fin, to_inf;
  logic [MW-1:0]           frac;
  logic [EW-1:0]           bexp;
  logic [EW+MW-1:0]        sum;
  logic [TW-1:0]           word;
  logic                    unused_top;
  logic signed [EXP_W-1:0] ebias;

  always_comb begin
    tiny  = u.exp < EMIN_S;
    diff  = EMIN_S - u.exp;
    sh    = !tiny ? 6'd0 : (diff > 13'sd63) ? 6'd63 : diff[5:0];
    sig   = {u.mant, 2'b00};
    shd   = sig >> sh;
    lmask = (sh >= 6'(SW)) ? '1 : ((SW'(1) << sh) - SW'(1));
    lost  = |(sig & lmask);
    unused_top = shd[SW-1];

    frac = shd[SW-2 -: MW];
    g    = shd[SW-2-MW];
    st   = (|shd[SW-3-MW:0]) | lost;

    case (rmode_e'(rmode))
      RM_NEAR: inc = g & (st | frac[0]);
      RM_UP:   inc = !u.sign & (g | st);
      RM_DOWN: inc = u.sign & (g | st);
      default: inc = 1'b0;
    endcase

    ebias    = u.exp + EMAX_S;
    bexp     = tiny ? '0 : ebias[EW-1:0];
    pre_ovf  = !tiny && (u.exp > EMAX_S);
    sum      = {bexp, frac} + (EW+MW)'(inc);
    post_ovf = &sum[EW+MW-1 -: EW];

    fin    = !(u.nan | u.inf | u.zero);
    ovf    = fin & (pre_ovf | post_ovf);
    to_inf = (rmode_e'(rmode) == RM_NEAR) ||
             ((rmode_e'(rmode) == RM_UP) && !u.sign) ||
             ((rmode_e'(rmode) == RM_DOWN) && u.sign);

    if (u.nan)
      word = {u.sign, {EW{1'b1}}, 1'b1, u.mant[MANT_W-3 -: MW-1]};
    else if (u.inf)
      word = {u.sign, {EW{1'b1}}, {MW{1'b0}}};
    else if (u.zero)
      word = {u.sign, {(EW+MW){1'b0}}};
    else if (ovf)
      word = to_inf ? {u.sign, {EW{1'b1}}, {MW{1'b0}}}
                    : {u.sign, {(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};
    else
      word = {u.sign, sum};

    res   = 64'(word);
    fl.nv = u.nan & u.snan;
    fl.of = ovf;
    fl.uf = fin & tiny & (g | st);
    fl.nx = fin & (g | st | ovf);
  end

endmodule

// File: rtl/fp_precision_cvt.sv
module fp_precision_cvt
  import pcv_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [63:0]  src_val,
  input  logic [127:0] dst_old,
  input  logic [1:0]   rmode,
  input  logic         merge,
  output logic         out_valid,
  output logic [4:0]   dst_idx,
  output logic         wr_en,
  output logic [127:0] wr_data,
  output logic         illegal,
  output logic [3:0]   fflags
);

  localparam int NFMT = 3;

  logic       dec_legal;
  fmt_e       src_fmt, dst_fmt;
  logic [4:0] rd;
  unp_t       unp;
  logic [63:0] cand    [NFMT];
  flags_t      cand_fl [NFMT];

  logic [1:0]   sel;
  logic [127:0] lowmask;
  logic [127:0] data_d;
  flags_t       flags_d;
  logic         valid_d, wen_d, ill_d;

  pcv_decode u_dec (
    .instr   (instr),
    .legal   (dec_legal),
    .src_fmt (src_fmt),
    .dst_fmt (dst_fmt),
    .rd      (rd)
  );

  pcv_unpack u_unp (
    .fmt (src_fmt),
    .raw (src_val),
    .u   (unp)
  );

  for (genvar k = 0; k < NFMT; k++) begin : g_dst
    pcv_round_pack #(
      .EW (fmt_ew(k)),
      .MW (fmt_mw(k))
    ) u_rp (
      .u     (unp),
      .rmode (rmode),
      .res   (cand[k]),
      .fl    (cand_fl[k])
    );
  end

  // next-state logic
  always_comb begin
    case (dst_fmt)
      FMT_H:   begin sel = 2'd0; lowmask = 128'(16'hFFFF); end
      FMT_S:   begin sel = 2'd1; lowmask = 128'(32'hFFFF_FFFF); end
      default: begin sel = 2'd2; lowmask = 128'(64'hFFFF_FFFF_FFFF_FFFF); end
    endcase
    if (dec_legal) begin
      data_d  = (merge ? (dst_old & ~lowmask) : '0) | ({64'b0, cand[sel]} & lowmask);
      flags_d = cand_fl[sel];
    end else begin
      data_d  = '0;
      flags_d = '0;
    end
    valid_d = in_valid;
    wen_d   = in_valid & dec_legal;
    ill_d   = in_valid & ~dec_legal;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      dst_idx   <= '0;
      wr_data   <= '0;
      fflags    <= '0;
    end else begin
      out_valid <= valid_d;
      wr_en     <= wen_d;
      illegal   <= ill_d;
      if (in_valid) begin
        dst_idx <= rd;
        wr_data <= data_d;
        fflags  <= flags_d;
      end
    end
  end

  a_r3_no_write_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  a_r3_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (fflags == 4'd0) && (wr_data == '0));

  a_r7_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    fflags[2] |-> fflags[0]);

  a_r8_underflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    fflags[1] |-> fflags[0]);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en && !illegal);

  a_r4_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !merge && dec_legal && dst_fmt == FMT_H) |=> (wr_data[127:16] == '0));

  a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge && dec_legal && dst_fmt == FMT_S) |=>
      (wr_data[127:32] == $past(dst_old[127:32])));

endmodule

// File: tb/fp_precision_cvt_tb.sv
module fp_precision_cvt_tb;

  localparam int PERIOD = 20;
  localparam int NV = 35;

  typedef struct packed {
    logic [1:0]  sf;
    logic [1:0]  df;
    logic [1:0]  rm;
    logic [63:0] a;
    logic [63:0] y;
    logic [3:0]  fl;
    logic [3:0]  rq;
  } vec_t;

  // formats: 00 single, 01 double, 11 half; flags {nv,of,uf,nx}
  localparam vec_t VECS [NV] = '{
    '{2'b11, 2'b00, 2'd0, 64'h3C00, 64'h3F800000, 4'h0, 4'd5},           // R5
    '{2'b11, 2'b01, 2'd0, 64'hC000, 64'hC000000000000000, 4'h0, 4'd5},   // R5
    '{2'b11, 2'b00, 2'd0, 64'h0001, 64'h33800000, 4'h0, 4'd5},           // R5 subnormal
    '{2'b11, 2'b00, 2'd0, 64'hFC00, 64'hFF800000, 4'h0, 4'd5},           // R5 -inf
    '{2'b11, 2'b01, 2'd0, 64'h8000, 64'h8000000000000000, 4'h0, 4'd5},   // R5 -0
    '{2'b00, 2'b01, 2'd0, 64'h3FC00000, 64'h3FF8000000000000, 4'h0, 4'd5},
    '{2'b00, 2'b01, 2'd0, 64'h00000001, 64'h36A0000000000000, 4'h0, 4'd5},
    '{2'b00, 2'b11, 2'd0, 64'h3F800000, 64'h3C00, 4'h0, 4'd2},           // R2
    '{2'b01, 2'b11, 2'd0, 64'h3FF0000000000000, 64'h3C00, 4'h0, 4'd2},
    '{2'b01, 2'b00, 2'd0, 64'h3FF0000000000000, 64'h3F800000, 4'h0, 4'd2},
    '{2'b00, 2'b11, 2'd0, 64'h3F801000, 64'h3C00, 4'h1, 4'd6},           // R6 tie
    '{2'b00, 2'b11, 2'd1, 64'h3F801000, 64'h3C01, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd2, 64'h3F801000, 64'h3C00, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd3, 64'h3F801000, 64'h3C00, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd2, 64'hBF801000, 64'hBC01, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd1, 64'hBF801000, 64'hBC00, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd0, 64'h3F803000, 64'h3C02, 4'h1, 4'd6},
    '{2'b00, 2'b11, 2'd0, 64'h47800000, 64'h7C00, 4'h5, 4'd7},           // R7
    '{2'b00, 2'b11, 2'd3, 64'h47800000, 64'h7BFF, 4'h5, 4'd7},
    '{2'b00, 2'b11, 2'd1, 64'hC7800000, 64'hFBFF, 4'h5, 4'd7},
    '{2'b00, 2'b11, 2'd2, 64'hC7800000, 64'hFC00, 4'h5, 4'd7},
    '{2'b00, 2'b11, 2'd0, 64'h477FF000, 64'h7C00, 4'h5, 4'd7},           // R7 carry
    '{2'b00, 2'b11, 2'd3, 64'h477FF000, 64'h7BFF, 4'h1, 4'd7},
    '{2'b00, 2'b11, 2'd0, 64'h33800000, 64'h0001, 4'h0, 4'd8},           // R8
    '{2'b00, 2'b11, 2'd0, 64'h33000000, 64'h0000, 4'h3, 4'd8},
    '{2'b00, 2'b11, 2'd1, 64'h33000000, 64'h0001, 4'h3, 4'd8},
    '{2'b00, 2'b11, 2'd0, 64'h38000000, 64'h0200, 4'h0, 4'd8},
    '{2'b01, 2'b00, 2'd0, 64'h0170000000000000, 64'h00000000, 4'h3, 4'd8},
    '{2'b01, 2'b00, 2'd1, 64'h0170000000000000, 64'h00000001, 4'h3, 4'd8},
    '{2'b00, 2'b11, 2'd0, 64'h7FC00000, 64'h7E00, 4'h0, 4'd9},           // R9
    '{2'b00, 2'b11, 2'd0, 64'h7F800001, 64'h7E00, 4'h8, 4'd9},
    '{2'b00, 2'b11, 2'd0, 64'hFF800001, 64'hFE00, 4'h8, 4'd9},
    '{2'b11, 2'b01, 2'd0, 64'h7D55, 64'h7FFD540000000000, 4'h8, 4'd9},
    '{2'b00, 2'b11, 2'd0, 64'h7FC12345, 64'h7E09, 4'h0, 4'd9},
    '{2'b01, 2'b11, 2'd0, 64'h7FF0000000000000, 64'h7C00, 4'h0, 4'd5}
  };

  localparam logic [127:0] OLD = 128'hA5A5_5A5A_DEAD_BEEF_0123_4567_89AB_CDEF;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [63:0]  src_val;
  logic [127:0] dst_old;
  logic [1:0]   rmode;
  logic         merge;
  logic         out_valid;
  logic [4:0]   dst_idx;
  logic         wr_en;
  logic [127:0] wr_data;
  logic         illegal;
  logic [3:0]   fflags;

  int checks;
  int fails;

  fp_precision_cvt u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .src_val   (src_val),
    .dst_old   (dst_old),
    .rmode     (rmode),
    .merge     (merge),
    .out_valid (out_valid),
    .dst_idx   (dst_idx),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .illegal   (illegal),
    .fflags    (fflags)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [1:0] sf, input logic [1:0] df,
                                     input logic [4:0] rn, input logic [4:0] rd);
    return {8'h1E, sf, 5'b10001, df, 5'b10000, rn, rd};
  endfunction

  function automatic logic [127:0] expect_wd(input logic [1:0] df, input logic [63:0] y,
                                             input logic [127:0] old, input logic mg);
    logic [127:0] m;
    m = (df == 2'b11) ? 128'(16'hFFFF) : (df == 2'b00) ? 128'(32'hFFFF_FFFF) : 128'(64'hFFFF_FFFF_FFFF_FFFF);
    return ((mg ? old : 128'd0) & ~m) | ({64'd0, y} & m);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [127:0] old,
                       input logic [1:0] rm, input logic mg);
    instr    = w;
    src_val  = a;
    dst_old  = old;
    rmode    = rm;
    merge    = mg;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_illegal(input logic [31:0] w, input string tag);
    issue(w, 64'h3F800000, OLD, 2'd0, 1'b1);
    chk(illegal === 1'b1 && wr_en === 1'b0, tag, {126'd0, illegal, wr_en}, 128'd2);
    chk(wr_data === '0 && fflags === 4'd0, tag, wr_data ^ 128'(fflags), 128'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    instr    = '0;
    src_val  = '0;
    dst_old  = '0;
    rmode    = '0;
    merge    = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid === 1'b0 && wr_en === 1'b0 && illegal === 1'b0, "R10 reset ctl",
        {125'd0, out_valid, wr_en, illegal}, 128'd0);
    chk(wr_data === '0 && fflags === 4'd0 && dst_idx === 5'd0, "R10 reset data",
        wr_data, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [4:0]   rd;
      logic         mg;
      logic [127:0] ew;
      string        tag;
      rd  = 5'(i);
      mg  = i[0];
      ew  = expect_wd(VECS[i].df, VECS[i].y, OLD, mg);
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      issue(mk(VECS[i].sf, VECS[i].df, 5'(31 - i), rd), VECS[i].a, OLD, VECS[i].rm, mg);
      // R1 / R4 / R10 on every vector
      chk(out_valid === 1'b1 && wr_en === 1'b1 && illegal === 1'b0, {"R1 ", tag},
          {125'd0, out_valid, wr_en, illegal}, 128'd6);
      chk(dst_idx === rd, {"R1 idx ", tag}, 128'(dst_idx), 128'(rd));
      chk(wr_data === ew, {"R4 data ", tag}, wr_data, ew);
      chk(fflags === VECS[i].fl, {"flags ", tag}, 128'(fflags), 128'(VECS[i].fl));
    end

    // R10: idle cycle drops the strobes
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && wr_en === 1'b0 && illegal === 1'b0, "R10 idle",
        {125'd0, out_valid, wr_en, illegal}, 128'd0);

    // R1: the double-to-half example word
    issue(32'h1E63C000, 64'hBFF0000000000000, OLD, 2'd0, 1'b0);
    chk(wr_en === 1'b1 && wr_data === 128'h0000_BC00, "R1 example word", wr_data, 128'hBC00);

    // R3: malformed words
    check_illegal(mk(2'b00, 2'b00, 5'd1, 5'd2), "R3 equal fields");
    check_illegal(mk(2'b10, 2'b00, 5'd1, 5'd2), "R3 reserved src");
    check_illegal(mk(2'b00, 2'b10, 5'd1, 5'd2), "R3 reserved dst");
    check_illegal(mk(2'b11, 2'b00, 5'd1, 5'd2) | 32'h8000_0000, "R3 top bit");
    check_illegal(mk(2'b11, 2'b00, 5'd1, 5'd2) ^ 32'h0002_0000, "R3 opcode bits");
    check_illegal(mk(2'b11, 2'b00, 5'd1, 5'd2) ^ 32'h0000_0400, "R3 low opcode bits");

    // R4: merge keeps upper bits of a double result
    issue(mk(2'b00, 2'b01, 5'd3, 5'd9), 64'hBF800000, OLD, 2'd0, 1'b1);
    chk(wr_data === {OLD[127:64], 64'hBFF0000000000000}, "R4 merge double",
        wr_data, {OLD[127:64], 64'hBFF0000000000000});
    issue(mk(2'b00, 2'b01, 5'd3, 5'd9), 64'hBF800000, OLD, 2'd0, 1'b0);
    chk(wr_data === {64'd0, 64'hBFF0000000000000}, "R4 zero double",
        wr_data, {64'd0, 64'hBFF0000000000000});

    in_valid = 1'b0;
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule